// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear Commands

This block is a watchdog counter that advances on a divided tick. When it runs out, it signals a system reset. If the system is halted, it signals a wake-up instead. Software keeps the watchdog from firing by giving two different clear commands, called kind A and kind B. The counter is cleared only when a command of one kind follows a command of the other kind. Giving the same command again and again has no effect, so a single stuck loop cannot keep the watchdog alive.

The block also keeps two status flags. The time-out flag records that the counter expired. The power-down flag records that a halt command was given. A halt command clears the counter and the prescaler, sets the power-down flag and clears the time-out flag. A completed clear pair clears both flags.

Each `tick` is divided by a `2**PRE_W` prescaler. The prescaler carry advances the `CNT_W`-bit counter. The counter expires on the tick that carries it past its all-ones value.

Top module: `wdog_pair_clear`

## Requirements
- R1: After `rst_n` is low, `timeout`, `wake`, `to_flag` and `pdf_flag` are 0, and the first expiry comes on exactly the `2**(CNT_W+PRE_W)`-th enabled tick (1024 ticks with the default parameters).
- R2: The counter advances only on a cycle with `en`=1 and `tick`=1. Ticks seen while `en`=0 do not count toward expiry.
- R3: On an expiry while `pdf_flag`=0, `timeout` is 1 for exactly the one cycle after the expiring tick, and `to_flag` becomes 1 on the same edge.
- R4: On an expiry while `pdf_flag`=1, `wake` pulses for one cycle instead of `timeout`. `to_flag` becomes 1 and `pdf_flag` stays 1. `timeout` and `wake` are never 1 together.
- R5: A clear completes when a lone `clr_a` strobe arrives and the last lone strobe was `clr_b`, or the reverse. Idle cycles between the two strobes do not matter. A cycle with both strobes high is ignored. A completed clear zeroes the counter and the prescaler, clears `to_flag` and `pdf_flag`, and forgets the stored strobe kind.
- R6: A strobe of the same kind as the last lone strobe does not clear anything.
- R7: `halt` has priority over clears and counting. It zeroes the counter and the prescaler, sets `pdf_flag`, clears `to_flag`, and forgets the stored strobe kind.
- R8: After an expiry the counter wraps to zero and keeps counting, so the next expiry comes a full period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous master reset |
| en | input | 1 | Counting enable |
| tick | input | 1 | Count-source pulse, one cycle per tick |
| clr_a | input | 1 | Clear command of kind A |
| clr_b | input | 1 | Clear command of kind B |
| halt | input | 1 | Halt command strobe |
| timeout | output | 1 | One-cycle reset request |
| wake | output | 1 | One-cycle wake-up request while halted |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
The clear logic is driven by short strobe sequences, each applied just after a halt so that `pdf_flag` shows whether a clear completed. The sequences include alternating pairs in both orders, runs of the same kind, pairs with idle cycles between them, and pairs with a both-high cycle between them. Together these separate true alternation from mere repetition and show that the both-high cycle is ignored.

The counter is checked by measuring how many ticks it takes to expire in several cases:
- after a partial run cut short by a valid pair, by a repeated single kind, or by a halt;
- with `en` low;
- back to back, to check the wrap.

This measurement shows whether each stimulus really zeroed the counter.

// File: rtl/wdog_pair_clear.sv
module wdog_pair_clear #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic clr_a,
  input  logic clr_b,
  input  logic halt,
  output logic timeout,
  output logic wake,
  output logic to_flag,
  output logic pdf_flag
);

  typedef enum logic [1:0] {K_NONE = 2'd0, K_A = 2'd1, K_B = 2'd2} kind_t;

  kind_t            last_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;

  wire step      = en & tick;
  wire pre_carry = step & (&pre_q);
  wire only_a    = clr_a & ~clr_b;
  wire only_b    = clr_b & ~clr_a;
  wire clr_done  = ~halt & ((only_a & (last_q == K_B)) | (only_b & (last_q == K_A)));
  wire expire    = pre_carry & (&cnt_q) & ~halt & ~clr_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      pre_q    <= '0;
      last_q   <= K_NONE;
      to_flag  <= 1'b0;
      pdf_flag <= 1'b0;
    end else if (halt) begin
      cnt_q    <= '0;
      pre_q    <= '0;
      last_q   <= K_NONE;
      to_flag  <= 1'b0;
      pdf_flag <= 1'b1;
    end else if (clr_done) begin
      cnt_q    <= '0;
      pre_q    <= '0;
      last_q   <= K_NONE;
      to_flag  <= 1'b0;
      pdf_flag <= 1'b0;
    end else begin
      if (only_a) last_q <= K_A;
      if (only_b) last_q <= K_B;
      if (step) pre_q <= pre_q + 1'b1;
      if (pre_carry) cnt_q <= cnt_q + 1'b1;
      if (expire) to_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeout <= 1'b0;
      wake    <= 1'b0;
    end else begin
      timeout <= expire & ~pdf_flag;
      wake    <= expire & pdf_flag;
    end
  end

  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout && wake));

  p_wake_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> pdf_flag);

  p_timeout_sets_to_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> to_flag);

  p_halt_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (pdf_flag && !to_flag && !timeout && !wake));

  p_repeat_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (only_a && last_q == K_A && pdf_flag && !halt) |=> pdf_flag);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !halt && !clr_a && !clr_b) |=> $stable(cnt_q));

  p_pair_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (only_b && last_q == K_A && !halt) |=> (!pdf_flag && !to_flag));

endmodule

// File: tb/test_wdog_pair_clear.sv
module test_wdog_pair_clear;
  localparam int PERIOD = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b1, tick = 1'b0, clr_a = 1'b0, clr_b = 1'b0, halt = 1'b0;
  logic timeout, wake, to_flag, pdf_flag;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  wdog_pair_clear i_wdog_pair_clear (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .clr_a(clr_a), .clr_b(clr_b),
    .halt(halt), .timeout(timeout), .wake(wake), .to_flag(to_flag), .pdf_flag(pdf_flag));

  // op codes, op0 in bits [2:1]: 1 = clr_a, 2 = clr_b, 3 = both high, 0 = idle; bit0 = expected pdf_flag
  localparam logic [8:0] VEC [10] = '{
    {8'h09, 1'b0}, {8'h06, 1'b0}, {8'h55, 1'b1}, {8'h0A, 1'b1}, {8'h21, 1'b0},
    {8'h2D, 1'b0}, {8'h0F, 1'b1}, {8'h25, 1'b0}, {8'h6A, 1'b0}, {8'h02, 1'b1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b1; tick = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  task automatic op(input logic [1:0] code);
    clr_a = code[0]; clr_b = code[1];
    cyc();
    clr_a = 1'b0; clr_b = 1'b0;
  endtask

  task automatic do_halt();
    halt = 1'b1; cyc(); halt = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0; cyc();
    end
  endtask

  task automatic measure(output int n, output bit was_wake);
    n = 0; was_wake = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
      n++;
      if (timeout || wake) begin
        was_wake = wake;
        cyc();
        chk(!timeout && !wake, "R3 pulse one cycle", int'(timeout | wake), 0);
        return;
      end
      cyc();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    bit w;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(!timeout && !wake && !to_flag && !pdf_flag, "R1 reset state",
        {timeout, wake, to_flag, pdf_flag}, 0);
    measure(n, w);
    chk(n == PERIOD && !w, "R1 first expiry", n, PERIOD);
    chk(to_flag == 1'b1, "R3 to_flag set", to_flag, 1);
    // R8 wrap and continue
    measure(n, w);
    chk(n == PERIOD, "R8 second expiry", n, PERIOD);
    op(2'd1); op(2'd2);
    chk(to_flag == 1'b0, "R5 pair clears to_flag", to_flag, 0);

    // vector table on clear sequences, R5 / R6
    foreach (VEC[v]) begin
      do_reset();
      do_halt();
      for (int k = 0; k < 4; k++) op(VEC[v][2*k+1 +: 2]);
      chk(pdf_flag == VEC[v][0], $sformatf("R5/R6 vector %0d", v), pdf_flag, VEC[v][0]);
    end

    // R5 valid pair zeroes counter
    do_reset(); run_ticks(500); op(2'd1); op(2'd2);
    measure(n, w);
    chk(n == PERIOD, "R5 pair restarts count", n, PERIOD);
    // R6 repeated kind leaves counter
    do_reset(); run_ticks(500); op(2'd1); op(2'd1); op(2'd1);
    measure(n, w);
    chk(n == PERIOD - 500, "R6 repeat no clear", n, PERIOD - 500);
    // R2 enable low ignores ticks
    do_reset(); run_ticks(100); en = 1'b0; run_ticks(300); en = 1'b1;
    measure(n, w);
    chk(n == PERIOD - 100, "R2 en low ignores ticks", n, PERIOD - 100);
    // R7 halt restarts counter and sets flags
    do_reset(); run_ticks(700); do_halt();
    chk(pdf_flag && !to_flag, "R7 halt flags", {pdf_flag, to_flag}, 2);
    measure(n, w);
    chk(n == PERIOD, "R7 halt zeroes count", n, PERIOD);
    // R4 expiry while halted gives wake
    chk(w == 1'b1, "R4 wake not timeout", w, 1);
    chk(to_flag && pdf_flag, "R4 flags after wake", {to_flag, pdf_flag}, 3);
    // R7 halt discards stored kind
    do_reset(); op(2'd1); do_halt(); op(2'd2);
    chk(pdf_flag == 1'b1, "R7 halt forgets kind", pdf_flag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule